// File: doc/BRIEF.md
# Dual DAC Serial Command Decoder

This block is the digital front end of a two-channel 12-bit converter. A host writes 16-bit command words over a three-wire serial port. The port has an active-low select, a serial clock and a data line. All three lines are oversampled in the core clock domain. Each word carries a 4-bit header and a 12-bit payload. The header picks a route for the payload and carries a speed flag and a power-down flag. The payload can go to the channel A latch, to the channel B latch, or to a shared holding buffer. One route loads channel A and copies the holding buffer into channel B on the same clock edge. This lets a host update both outputs at once.

A frame starts when select falls. Bits are taken most significant first, one on each falling edge of the serial clock. The word is committed after its sixteenth bit. If select rises first, the bits received so far are committed, left-aligned. The two channel values and the two mode flags are driven straight out so that the analog side can use them.

Top module: `dual_dac_cmd_decoder`

## Requirements
- R1: After reset, `dac_a`, `dac_b`, the holding buffer, `fast_mode` and `power_down` are all zero.
- R2: A frame begins on a falling edge of `sel_n`. While `sel_n` is low, each falling edge of `ser_clk` samples `ser_data`, first bit first. In the word, bit 15 is the upper route bit, bit 14 the speed flag, bit 13 the power-down flag, bit 12 the lower route bit, and bits 11..0 the payload.
- R3: A frame is committed once its 16th bit is sampled, while `sel_n` is still low. Later serial clock edges in the same frame are ignored.
- R4: Route code 00 writes the payload to both `dac_b` and the holding buffer.
- R5: Route code 01 writes the payload to the holding buffer only. `dac_a` and `dac_b` keep their values.
- R6: Route code 10 writes the payload to `dac_a`. On the same edge, `dac_b` takes the holding buffer value from before the commit.
- R7: Route code 11 changes no latch, the buffer and neither flag.
- R8: Every commit with a route code other than 11 sets `fast_mode` to bit 14 and `power_down` to bit 13.
- R9: If `sel_n` rises after n bits, with 1 ≤ n < 16, the n bits are committed as the top n bits of the word and the rest are zero. A frame with no bits commits nothing. A short frame leaves no trace in the next full frame.
- R10: `ser_clk` and `ser_data` activity while `sel_n` is high has no effect.
- R11: Outputs change one core clock after the commit decision, never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Serial select, active low, asynchronous to `clk` |
| ser_clk | input | 1 | Serial clock, sampled on its falling edge |
| ser_data | input | 1 | Serial data, first bit is bit 15 |
| dac_a | output | 12 | Channel A latch value |
| dac_b | output | 12 | Channel B latch value |
| fast_mode | output | 1 | 1 = fast settling mode, 0 = slow |
| power_down | output | 1 | 1 = powered down, 0 = normal |

## Verification
The assertions assume that each serial line holds a level for longer than the synchronizer depth plus one core clock. They also assume that data is stable when the serial clock falls, and that select and the serial clock never change in the same core cycle. The stimulus holds each serial phase for three core clocks. It sets data one phase before each falling clock edge. It keeps the serial clock high whenever select moves. The bench sweeps all sixteen header values with several payloads and every short-frame length. It compares the outputs against an arithmetic model after each frame has settled.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    parameter int unsigned DATA_W = 12;
    parameter int unsigned HDR_W  = 4;
    parameter int unsigned WORD_W = DATA_W + HDR_W;
    parameter int unsigned CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        RT_B_AND_BUF = 2'b00,
        RT_BUF_ONLY  = 2'b01,
        RT_A_XFER    = 2'b10,
        RT_RSVD      = 2'b11
    } route_e;

    typedef struct packed {
        logic              sel_hi;
        logic              fast;
        logic              pdown;
        logic              sel_lo;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    function automatic route_e route_of(input cmd_word_t w);
        return route_e'({w.sel_hi, w.sel_lo});
    endfunction

    function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] v,
                                                     input logic [CNT_W-1:0]  n);
        return v << (CNT_W'(WORD_W) - n);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import dac_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n_s,
    input  logic      sck_s,
    input  logic      sdat_s,
    output logic      cmt_vld,
    output cmd_word_t cmt_word
);
    logic              sel_q, sck_q, done;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              sel_fall, sel_rise, sck_fall;
    logic [WORD_W-1:0] shift_nxt;

    always_comb begin
        sel_fall  = sel_q & ~sel_n_s;
        sel_rise  = ~sel_q & sel_n_s;
        sck_fall  = sck_q & ~sck_s;
        shift_nxt = {shreg[WORD_W-2:0], sdat_s};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b1;
            sck_q    <= 1'b1;
            done     <= 1'b1;
            shreg    <= '0;
            cnt      <= '0;
            cmt_vld  <= 1'b0;
            cmt_word <= '0;
        end else begin
            sel_q   <= sel_n_s;
            sck_q   <= sck_s;
            cmt_vld <= 1'b0;
            if (sel_fall) begin
                shreg <= '0;
                cnt   <= '0;
                done  <= 1'b0;
            end else if (!sel_n_s && sck_fall && !done) begin
                shreg <= shift_nxt;
                cnt   <= cnt + CNT_W'(1);
                if (cnt == CNT_W'(WORD_W - 1)) begin
                    done     <= 1'b1;
                    cmt_vld  <= 1'b1;
                    cmt_word <= cmd_word_t'(shift_nxt);
                end
            end else if (sel_rise && !done && cnt != '0) begin
                done     <= 1'b1;
                cmt_vld  <= 1'b1;
                cmt_word <= cmd_word_t'(left_align(shreg, cnt));
            end
        end
    end
endmodule

// File: rtl/cmd_apply.sv
module cmd_apply
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmt_vld,
    input  cmd_word_t         cmt_word,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic [DATA_W-1:0] hold_buf,
    output logic              fast_mode,
    output logic              power_down
);
    route_e rt;
    assign rt = route_of(cmt_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_a      <= '0;
            dac_b      <= '0;
            hold_buf   <= '0;
            fast_mode  <= 1'b0;
            power_down <= 1'b0;
        end else if (cmt_vld && rt != RT_RSVD) begin
            fast_mode  <= cmt_word.fast;
            power_down <= cmt_word.pdown;
            unique case (rt)
                RT_B_AND_BUF: begin
                    dac_b    <= cmt_word.data;
                    hold_buf <= cmt_word.data;
                end
                RT_BUF_ONLY: hold_buf <= cmt_word.data;
                RT_A_XFER: begin
                    dac_a <= cmt_word.data;
                    dac_b <= hold_buf;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dual_dac_cmd_decoder.sv
module dual_dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic              fast_mode,
    output logic              power_down
);
    logic [2:0]        sync_q;
    logic              cmt_vld;
    cmd_word_t         cmt_word;
    logic [DATA_W-1:0] hold_buf;

    pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) i_sync (
        .clk(clk), .rst(rst),
        .d_in({sel_n, ser_clk, ser_data}),
        .q_out(sync_q)
    );

    frame_shifter i_shift (
        .clk(clk), .rst(rst),
        .sel_n_s(sync_q[2]), .sck_s(sync_q[1]), .sdat_s(sync_q[0]),
        .cmt_vld(cmt_vld), .cmt_word(cmt_word)
    );

    cmd_apply i_apply (
        .clk(clk), .rst(rst),
        .cmt_vld(cmt_vld), .cmt_word(cmt_word),
        .dac_a(dac_a), .dac_b(dac_b), .hold_buf(hold_buf),
        .fast_mode(fast_mode), .power_down(power_down)
    );
endmodule

// File: rtl/dac_cmd_checker.sv
module dac_cmd_checker
    import dac_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmt_vld,
    input logic [WORD_W-1:0] cmt_word,
    input logic [DATA_W-1:0] hold_buf,
    input logic [DATA_W-1:0] dac_a,
    input logic [DATA_W-1:0] dac_b,
    input logic              fast_mode,
    input logic              power_down
);
    logic [1:0] rt;
    assign rt = {cmt_word[WORD_W-1], cmt_word[WORD_W-4]};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) && !rst |-> dac_a == '0 && dac_b == '0 && hold_buf == '0 && !fast_mode && !power_down); // R1
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmt_vld |=> !cmt_vld); // R3
    AST_ROUTE_B_BUF: assert property (@(posedge clk) disable iff (rst)
        cmt_vld && rt == 2'b00 |=> dac_b == $past(cmt_word[DATA_W-1:0]) && hold_buf == $past(cmt_word[DATA_W-1:0]) && $stable(dac_a)); // R4
    AST_ROUTE_BUF_ONLY: assert property (@(posedge clk) disable iff (rst)
        cmt_vld && rt == 2'b01 |=> hold_buf == $past(cmt_word[DATA_W-1:0]) && $stable(dac_a) && $stable(dac_b)); // R5
    AST_ROUTE_A_XFER: assert property (@(posedge clk) disable iff (rst)
        cmt_vld && rt == 2'b10 |=> dac_a == $past(cmt_word[DATA_W-1:0]) && dac_b == $past(hold_buf)); // R6
    AST_ROUTE_RSVD: assert property (@(posedge clk) disable iff (rst)
        cmt_vld && rt == 2'b11 |=> $stable(dac_a) && $stable(dac_b) && $stable(hold_buf) && $stable(fast_mode) && $stable(power_down)); // R7
    AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (rst)
        cmt_vld && rt != 2'b11 |=> fast_mode == $past(cmt_word[WORD_W-2]) && power_down == $past(cmt_word[WORD_W-3])); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmt_vld |=> $stable(dac_a) && $stable(dac_b) && $stable(hold_buf) && $stable(fast_mode) && $stable(power_down)); // R11
endmodule

bind dual_dac_cmd_decoder dac_cmd_checker i_chk (
    .clk(clk), .rst(rst), .cmt_vld(cmt_vld), .cmt_word(cmt_word),
    .hold_buf(hold_buf), .dac_a(dac_a), .dac_b(dac_b),
    .fast_mode(fast_mode), .power_down(power_down)
);

// File: tb/test_dual_dac_cmd_decoder.sv
module test_dual_dac_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, ser_clk = 1'b1, ser_data = 1'b0;
    logic [11:0] dac_a, dac_b;
    logic        fast_mode, power_down;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_a = '0, m_b = '0, m_buf = '0;
    logic        m_fast = 1'b0, m_pd = 1'b0;

    always #5 clk = ~clk;

    dual_dac_cmd_decoder i_dual_dac_cmd_decoder (
        .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .dac_a(dac_a), .dac_b(dac_b), .fast_mode(fast_mode), .power_down(power_down)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string rq_dac, input string rq_flag);
        chk(rq_dac, "dac_a", dac_a, m_a);
        chk(rq_dac, "dac_b", dac_b, m_b);
        chk(rq_flag, "fast_mode", {11'd0, fast_mode}, {11'd0, m_fast});
        chk(rq_flag, "power_down", {11'd0, power_down}, {11'd0, m_pd});
    endtask

    // R8 flag update, R4..R7 routing, R9 left alignment
    task automatic model_commit(input logic [15:0] w, input int n);
        logic [15:0] eff;
        if (n == 0) return;
        eff = (n >= 16) ? w : ((w >> (16 - n)) << (16 - n));
        case ({eff[15], eff[12]})
            2'b00: begin m_b = eff[11:0]; m_buf = eff[11:0]; end
            2'b01: m_buf = eff[11:0];
            2'b10: begin m_b = m_buf; m_a = eff[11:0]; end
            default: ;
        endcase
        if ({eff[15], eff[12]} != 2'b11) begin
            m_fast = eff[14];
            m_pd   = eff[13];
        end
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = w[15 - i];
            wait_cyc(3);
            ser_clk = 1'b0;
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
        end
    endtask

    task automatic frame(input logic [15:0] w, input int n);
        sel_n = 1'b0;
        wait_cyc(4);
        shift_bits(w, n);
        wait_cyc(4);
        sel_n = 1'b1;
        wait_cyc(10);
        model_commit(w, n);
    endtask

    function automatic string route_req(input logic [15:0] w);
        case ({w[15], w[12]})
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] w;
        logic [11:0] d;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        check_all("R1", "R1");

        // R2 layout: route 10 with fast flag, payload ABC
        frame(16'hCABC, 16);
        check_all("R2", "R2");

        // R3: outputs updated after 16 bits while select still low; extra bits ignored
        sel_n = 1'b0;
        wait_cyc(4);
        shift_bits(16'h0123, 16);
        wait_cyc(8);
        model_commit(16'h0123, 16);
        check_all("R3", "R3");
        shift_bits(16'hFFFF, 6);
        wait_cyc(4);
        sel_n = 1'b1;
        wait_cyc(10);
        check_all("R3", "R3");

        // R5 then R6: buffer-only write becomes visible on channel B via transfer
        frame(16'h1777, 16);
        chk("R5", "dac_b after buffer-only", dac_b, 12'h123);
        frame(16'h8555, 16);
        chk("R6", "dac_b from buffer", dac_b, 12'h777);
        chk("R6", "dac_a payload", dac_a, 12'h555);

        // Sweep of all header codes and several payloads (R4..R8)
        for (int h = 0; h < 16; h++) begin
            for (int k = 0; k < 8; k++) begin
                if (k == 0) d = 12'h000;
                else if (k == 7) d = 12'hFFF;
                else d = 12'((h * 397 + k * 1231) ^ (k * k * 77));
                w = {h[3:0], d};
                frame(w, 16);
                check_all(route_req(w), "R8");
            end
        end

        // R9: short frames of every length, each followed by a full frame
        frame(16'h0000, 0);
        check_all("R9", "R9");
        for (int n = 1; n < 16; n++) begin
            w = 16'hA5C3 ^ 16'(n * 16'h1111);
            frame(w, n);
            check_all("R9", "R9");
            frame(16'h4000 | 16'(n * 16'h0111), 16);
            check_all("R9", "R9");
        end

        // R10: serial activity with select high
        for (int i = 0; i < 20; i++) begin
            ser_data = i[0] ^ i[2];
            wait_cyc(3);
            ser_clk = 1'b0;
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
        end
        wait_cyc(6);
        check_all("R10", "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule